// File: doc/BRIEF.md
# Configurable GPIO Port Register

This block is one 8-bit general-purpose I/O port controlled over a small synchronous register bus. Each pin has one bit in an output latch and one bit in a direction register. Each pin drives three pad signals: an output value, an output enable, and a separate high-side drive enable. The high-side enable lets the pad be run as an open-drain driver. A control bit switches every driving pin to open-drain operation, in which the pin can only pull low and an external pull-up supplies the high level.

Compile-time parameters set three things. The first is where a read of an output pin takes its value: the sensed pad level or the output latch. The second is a mask of bit positions that are not built. The third is an optional fixed direction, either output-only or input-only. An alternate-function interface gives a pin to another block while its enable is high. Pad inputs pass through a two-stage synchronizer before they reach the read path.

Register map, selected by `bus_addr`: 0 is the output latch (reads return pin data), 1 is the direction register, 2 is the control register with the open-drain bit at bit 0, and 3 is reserved. Writes take effect on the clock edge where `bus_sel` and `bus_wr` are both high. `bus_rdata` follows `bus_addr` combinationally.

Top module: `gpio_port`

## Requirements
- R1: After reset the direction register, output latch and open-drain bit are all 0, so no pin drives in the bidirectional mode, and addresses 1 and 2 read 0.
- R2: A direction bit of 1 sets that pin's `pad_oe` and drives the latched bit on `pad_out`. A direction bit of 0 clears `pad_oe`. The change appears on the clock edge that completes the register write.
- R3: A data write while a pin is an input leaves `pad_oe` low. The stored bit appears on the driven pin as soon as the direction bit is later set.
- R4: A read of an input pin returns the pad level. A change on `pad_in` becomes visible to reads two clock edges later, and not after one.
- R5: A read of an output pin returns the synchronized pad level when `RDBK_PIN`=1, and the output latch bit when `RDBK_PIN`=0.
- R6: When control bit 0 is 1, `pad_hi_en` is 0 on every pin and `pad_oe` is unchanged. When the bit is 0, `pad_hi_en` equals `pad_oe`. `pad_hi_en` is never set on a pin whose `pad_oe` is low.
- R7: Bit positions that are 0 in `IMPL_MASK` ignore writes, never assert `pad_oe`, `pad_out` or `pad_hi_en`, and read as 0 at addresses 0 and 1.
- R8: With `FIX_DIR`=1 (output-only), every implemented pin drives at all times, reads of address 0 return the latch, and the direction register reads 0 and ignores writes.
- R9: With `FIX_DIR`=2 (input-only), writes to address 0 have no effect, so `pad_oe` and `pad_out` stay 0 outside the alternate function, and reads of address 0 return the pad levels.
- R10: While `alt_en` is set for a pin, that pin's `pad_oe` and `pad_out` follow `alt_oe` and `alt_out`. Other pins are unaffected. Clearing `alt_en` restores general-purpose control.
- R11: Address 3 reads as 0, and address 2 returns the open-drain bit at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data for bus_addr |
| pad_in | input | W | Sensed pad levels |
| pad_out | output | W | Value presented to the pad driver |
| pad_oe | output | W | Pad output enable (low-side drive enable) |
| pad_hi_en | output | W | High-side drive enable |
| alt_en | input | W | Per-pin alternate-function takeover |
| alt_out | input | W | Alternate-function output value |
| alt_oe | input | W | Alternate-function output enable |

## Verification
The stimulus mixes inputs and outputs in one direction pattern (low nibble out, high nibble in). Pad levels are chosen to differ from the latch, so pin readback and latch readback give different words, and a swapped select or a reversed direction polarity shows up in the read value. A preset pattern is written before the direction bits are set, which separates a latch that keeps writes to input pins from one that discards them. A single pad change is sampled after one edge and after two, which catches a missing or extra synchronizer stage. The fixed-direction and masked variants run as separate instances on the same bus, and the alternate-function pattern uses an enable that overlaps both driven pins and undriven pins.

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int              W         = 8,
  parameter logic [W-1:0]    IMPL_MASK = {W{1'b1}},
  parameter bit              RDBK_PIN  = 1'b1,
  parameter int              FIX_DIR   = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_sel,
  input  logic         bus_wr,
  input  logic [1:0]   bus_addr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_hi_en,
  input  logic [W-1:0] alt_en,
  input  logic [W-1:0] alt_out,
  input  logic [W-1:0] alt_oe
);
  localparam bit HAS_DIR  = (FIX_DIR == 0);
  localparam bit DATA_WR  = (FIX_DIR != 2);
  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_DIR  = 2'd1;
  localparam logic [1:0] A_CTRL = 2'd2;

  logic [W-1:0] lat_q, dir_q, sync1_q, sync2_q;
  logic         wor_q;
  logic [W-1:0] dir_eff, lat_sel, data_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q   <= '0;
      dir_q   <= '0;
      wor_q   <= 1'b0;
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
      if (bus_sel && bus_wr) begin
        case (bus_addr)
          A_DATA:  if (DATA_WR) lat_q <= bus_wdata & IMPL_MASK;
          A_DIR:   if (HAS_DIR) dir_q <= bus_wdata & IMPL_MASK;
          A_CTRL:  wor_q <= bus_wdata[0];
          default: ;
        endcase
      end
    end
  end

  assign dir_eff = (FIX_DIR == 1) ? IMPL_MASK :
                   (FIX_DIR == 2) ? '0 : dir_q;

  assign pad_oe    = IMPL_MASK & ((alt_en & alt_oe)  | (~alt_en & dir_eff));
  assign pad_out   = IMPL_MASK & ((alt_en & alt_out) | (~alt_en & lat_q));
  assign pad_hi_en = pad_oe & {W{~wor_q}};

  assign lat_sel = (FIX_DIR == 1) ? IMPL_MASK :
                   RDBK_PIN       ? '0 : dir_eff;
  assign data_rd = IMPL_MASK & ((lat_sel & lat_q) | (~lat_sel & sync2_q));

  always_comb begin
    case (bus_addr)
      A_DATA:  bus_rdata = data_rd;
      A_DIR:   bus_rdata = HAS_DIR ? dir_q : '0;
      A_CTRL:  bus_rdata = {{(W-1){1'b0}}, wor_q};
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int           W         = 8,
  parameter logic [W-1:0] IMPL_MASK = {W{1'b1}},
  parameter int           FIX_DIR   = 0
) (
  input logic         clk,
  input logic         rst_n,
  input logic         bus_sel,
  input logic         bus_wr,
  input logic [1:0]   bus_addr,
  input logic [W-1:0] bus_wdata,
  input logic [W-1:0] alt_en,
  input logic [W-1:0] pad_out,
  input logic [W-1:0] pad_oe,
  input logic [W-1:0] pad_hi_en
);
  // R7
  unimpl_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe | pad_out | pad_hi_en) & ~IMPL_MASK) == '0);

  // R6
  hi_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_hi_en & ~pad_oe) == '0);

  // R6
  wor_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == 2'd2 && bus_wdata[0]) |=> pad_hi_en == '0);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rst_n) && alt_en == '0) |->
      (pad_oe == ((FIX_DIR == 1) ? IMPL_MASK : '0)));

  generate
    if (FIX_DIR == 0) begin : g_bidir
      // R2
      dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == 2'd1 && alt_en == '0) |=>
          (alt_en != '0 || pad_oe == ($past(bus_wdata) & IMPL_MASK)));
    end
    if (FIX_DIR == 2) begin : g_inonly
      // R9
      in_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alt_en == '0) |-> (pad_oe == '0 && pad_out == '0));
    end
  endgenerate
endmodule

bind gpio_port gpio_port_chk #(.W(W), .IMPL_MASK(IMPL_MASK), .FIX_DIR(FIX_DIR)) u_gpio_port_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .alt_en(alt_en),
  .pad_out(pad_out), .pad_oe(pad_oe), .pad_hi_en(pad_hi_en)
);

// File: tb/gpio_port_bench.sv
`timescale 1ns/1ps
module gpio_port_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = '0, pad_in = '0;
  logic [7:0] alt_en = '0, alt_out = '0, alt_oe = '0;

  logic [7:0] rd_m, out_m, oe_m, hi_m;
  logic [7:0] rd_l, out_l, oe_l, hi_l;
  logic [7:0] rd_o, out_o, oe_o, hi_o;
  logic [7:0] rd_i, out_i, oe_i, hi_i;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_port #(.W(8), .IMPL_MASK(8'h3F), .RDBK_PIN(1'b1), .FIX_DIR(0)) u_gpio_port (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd_m), .pad_in(pad_in), .pad_out(out_m),
    .pad_oe(oe_m), .pad_hi_en(hi_m), .alt_en(alt_en), .alt_out(alt_out), .alt_oe(alt_oe));

  gpio_port #(.W(8), .IMPL_MASK(8'hFF), .RDBK_PIN(1'b0), .FIX_DIR(0)) u_gpio_port_lat (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd_l), .pad_in(pad_in), .pad_out(out_l),
    .pad_oe(oe_l), .pad_hi_en(hi_l), .alt_en(alt_en), .alt_out(alt_out), .alt_oe(alt_oe));

  gpio_port #(.W(8), .IMPL_MASK(8'hFF), .RDBK_PIN(1'b1), .FIX_DIR(1)) u_gpio_port_out (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd_o), .pad_in(pad_in), .pad_out(out_o),
    .pad_oe(oe_o), .pad_hi_en(hi_o), .alt_en(alt_en), .alt_out(alt_out), .alt_oe(alt_oe));

  gpio_port #(.W(8), .IMPL_MASK(8'hFF), .RDBK_PIN(1'b1), .FIX_DIR(2)) u_gpio_port_in (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd_i), .pad_in(pad_in), .pad_out(out_i),
    .pad_oe(oe_i), .pad_hi_en(hi_i), .alt_en(alt_en), .alt_out(alt_out), .alt_oe(alt_oe));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [1:0] a);
    @(negedge clk);
    bus_addr = a;
    #1;
  endtask

  task automatic t_reset;
    chk("R1 main oe", oe_m, 8'h00);
    chk("R1 main out", out_m, 8'h00);
    chk("R8 out-only oe at reset", oe_o, 8'hFF);
    rd(2'd1); chk("R1 dir reads 0", rd_m, 8'h00);
    rd(2'd2); chk("R1 ctrl reads 0", rd_m, 8'h00);
  endtask

  task automatic t_preset;
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h5A);
    chk("R3 preset keeps oe low", oe_m, 8'h00);
    chk("R3 preset keeps oe low (lat)", oe_l, 8'h00);
    wr(2'd1, 8'hFF);
    chk("R3 preset value drives", out_m, 8'h1A);
    chk("R3 preset value drives (lat)", out_l, 8'h5A);
    chk("R2 oe follows dir", oe_m, 8'h3F);
  endtask

  task automatic t_dir;
    wr(2'd0, 8'hA5);
    wr(2'd1, 8'h0F);
    chk("R2 oe low nibble", oe_m, 8'h0F);
    chk("R2 out latch", out_m, 8'h25);
    chk("R6 hi_en equals oe", hi_m, 8'h0F);
    rd(2'd1); chk("R2 dir readback", rd_m, 8'h0F);
  endtask

  task automatic t_readback;
    wr(2'd0, 8'h5A);
    wr(2'd1, 8'h0F);
    pad_in = 8'hC3;
    repeat (3) @(negedge clk);
    rd(2'd0);
    chk("R5 pin readback", rd_m, 8'h03);
    chk("R5 latch readback", rd_l, 8'hCA);
    @(negedge clk); pad_in = 8'h3C; bus_addr = 2'd0;
    @(negedge clk); #1;
    chk("R4 one edge old value", rd_m, 8'h03);
    @(negedge clk); #1;
    chk("R4 two edges new value", rd_m, 8'h3C);
    chk("R4 input bits from pin", rd_l & 8'hF0, 8'h30);
  endtask

  task automatic t_wor;
    wr(2'd1, 8'hFF);
    wr(2'd2, 8'h01);
    chk("R6 hi_en off", hi_m, 8'h00);
    chk("R6 oe kept", oe_m, 8'h3F);
    chk("R6 out-only hi_en off", hi_o, 8'h00);
    rd(2'd2); chk("R11 ctrl bit0", rd_m, 8'h01);
    wr(2'd2, 8'h00);
    chk("R6 hi_en restored", hi_m, 8'h3F);
  endtask

  task automatic t_mask;
    wr(2'd0, 8'hFF);
    wr(2'd1, 8'hFF);
    chk("R7 oe masked", oe_m, 8'h3F);
    chk("R7 out masked", out_m, 8'h3F);
    rd(2'd1); chk("R7 dir masked", rd_m, 8'h3F);
    pad_in = 8'hFF;
    repeat (3) @(negedge clk);
    rd(2'd0); chk("R7 data read masked", rd_m, 8'h3F);
  endtask

  task automatic t_alt;
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h0F);
    @(negedge clk);
    alt_en = 8'h31; alt_oe = 8'h30; alt_out = 8'h11;
    #1;
    chk("R10 alt oe", oe_m, 8'h3E);
    chk("R10 alt out", out_m, 8'h11);
    @(negedge clk);
    alt_en = 8'h00; alt_oe = 8'h00; alt_out = 8'h00;
    #1;
    chk("R10 gp oe restored", oe_m, 8'h0F);
    chk("R10 gp out restored", out_m, 8'h00);
  endtask

  task automatic t_fixed;
    wr(2'd0, 8'h96);
    wr(2'd1, 8'h55);
    pad_in = 8'h0F;
    repeat (3) @(negedge clk);
    chk("R8 out-only oe", oe_o, 8'hFF);
    chk("R8 out-only out", out_o, 8'h96);
    rd(2'd0); chk("R8 out-only reads latch", rd_o, 8'h96);
    chk("R9 in-only reads pins", rd_i, 8'h0F);
    rd(2'd1); chk("R8 out-only dir reads 0", rd_o, 8'h00);
    chk("R9 in-only oe", oe_i, 8'h00);
    chk("R9 in-only out ignores write", out_i, 8'h00);
    rd(2'd3); chk("R11 reserved reads 0", rd_m, 8'h00);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset;
    t_preset;
    t_dir;
    t_readback;
    t_wor;
    t_mask;
    t_alt;
    t_fixed;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule